// File: doc/BRIEF.md
# Dual-Output Waveform PWM Timer

This block is one timer channel set up to make waveforms. A single up-counter drives two PWM outputs, A and B. The two outputs share the counter and its period. The counter advances on a tick. The tick comes from the input clock divided by 2, 8, 32 or 128, or from a slow-tick strobe supplied from outside. The counter returns to zero on the tick after it equals the period register. Each output has its own compare register. Each output also has three action fields: one for its own compare match, one for the period match and one for a software trigger.

Software configures the block through a plain write port. A select code chooses the mode word, compare A, compare B or the period register, and a write to any of them takes effect on the next cycle. A command port starts or stops the counter and issues software triggers. A trigger applies each output's trigger action and restarts the counter from zero, even while the counter is stopped. The counter value, the running flag and both output levels are visible on ports.

Top module: `wave_pwm_pair`

## Requirements
- R1: A synchronous reset clears the counter, both outputs, the running flag, the mode word and the three compare registers.
- R2: Mode bits [2:0] select the tick. Codes 0, 1, 2 and 3 give one tick every 2, 8, 32 and 128 clocks: the divider starts at zero on the first clock after reset, and a tick falls on each clock where the low 1, 3, 5 or 7 divider bits are all ones. Codes 4 to 7 use the slow_tick input as the tick.
- R3: While running, the counter rises by one on each tick. On a tick when it equals the period register, it goes to zero instead.
- R4: Action codes are 00 none, 01 set, 10 clear and 11 toggle. On a running tick, output A applies mode bits [4:3] when the counter equals compare A, and output B applies bits [10:9] when the counter equals compare B. With no event, each output holds its level.
- R5: On a running tick where the counter equals the period register, output A applies mode bits [6:5] and output B applies bits [12:11].
- R6: A software trigger applies mode bits [8:7] to A and bits [14:13] to B, and sets the counter to zero on the next cycle, whether or not the counter is running.
- R7: cmd_en starts the counter on the next cycle and cmd_dis stops it. If both are given together, cmd_dis wins. cmd_trig may be given with cmd_en.
- R8: Events that fall in the same cycle are resolved in this order: a software trigger beats a period match, and a period match beats the output's own compare match.
- R9: While the counter is stopped, the counter and both outputs keep their values, except when a software trigger arrives.
- R10: A write with cfg_sel 0 loads the mode word, 1 loads compare A, 2 loads compare B and 3 loads the period. Each write is used from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| slow_tick | input | 1 | External slow-tick strobe, used when the select code is 4 to 7 |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 mode, 1 compare A, 2 compare B, 3 period |
| cfg_wdata | input | CNT_W | Write data; the mode word uses bits [14:0] |
| cmd_en | input | 1 | Start counting |
| cmd_dis | input | 1 | Stop counting |
| cmd_trig | input | 1 | Software trigger |
| cnt_o | output | CNT_W | Current counter value |
| running_o | output | 1 | Counter is running |
| out_a | output | 1 | PWM output A |
| out_b | output | 1 | PWM output B |

## Verification
Every result is registered. A tick, command or write sampled at one rising edge therefore shows on cnt_o, running_o and the outputs right after that edge, one cycle later. A predictor in the bench updates at the rising edge from the same inputs the design sees. It queues the state it expects after that edge, and a monitor pops each entry and compares it at the following falling edge. Directed checks also sample at falling edges, right after the command or write has been taken. The period for the divided ticks is checked by counting cycles between rising edges of output A, (period+1) times the divisor.

// File: rtl/wg_pkg.sv
package wg_pkg;
  typedef enum logic [1:0] {
    ACT_NONE = 2'b00,
    ACT_SET  = 2'b01,
    ACT_CLR  = 2'b10,
    ACT_TGL  = 2'b11
  } act_e;

  // Packed MSB first so that clk_sel lands on bits [2:0].
  typedef struct packed {
    act_e       b_sw;
    act_e       b_rc;
    act_e       b_cmp;
    act_e       a_sw;
    act_e       a_rc;
    act_e       a_cmp;
    logic [2:0] clk_sel;
  } mode_t;

  localparam int MODE_W = 15;

  function automatic logic apply_act(act_e a, logic cur);
    case (a)
      ACT_SET: return 1'b1;
      ACT_CLR: return 1'b0;
      ACT_TGL: return ~cur;
      default: return cur;
    endcase
  endfunction
endpackage

// File: rtl/wg_prescale.sv
module wg_prescale #(
  parameter int NUM_DIV = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] sel,
  input  logic       slow_tick,
  output logic       tick
);
  localparam int DIV_W = 2 * NUM_DIV - 1;

  logic [DIV_W-1:0]   div_q;
  logic [NUM_DIV-1:0] tap;

  always_ff @(posedge clk) begin
    if (rst) div_q <= '0;
    else     div_q <= div_q + 1'b1;
  end

  // Tap i fires once every 2^(2i+1) clocks.
  for (genvar i = 0; i < NUM_DIV; i++) begin : g_tap
    assign tap[i] = &div_q[2*i:0];
  end

  always_comb begin
    if (sel < 3'(NUM_DIV)) tick = tap[sel[1:0]];
    else                   tick = slow_tick;
  end

  AST_DIV2_SPACING: assert property (@(posedge clk) disable iff (rst)
    (sel == 3'd0 && tick) |=> !tap[0]);  // R2
endmodule

// File: rtl/wg_counter.sv
module wg_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             cmd_en,
  input  logic             cmd_dis,
  input  logic             cmd_trig,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] cnt,
  output logic             run,
  output logic             at_period
);
  assign at_period = (cnt == period);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      run <= 1'b0;
    end else begin
      if (cmd_dis)     run <= 1'b0;
      else if (cmd_en) run <= 1'b1;

      if (cmd_trig)         cnt <= '0;
      else if (run && tick) cnt <= at_period ? '0 : cnt + 1'b1;
    end
  end

  AST_TRIG_ZEROES: assert property (@(posedge clk) disable iff (rst)
    cmd_trig |=> (cnt == '0));  // R6
  AST_PERIOD_WRAP: assert property (@(posedge clk) disable iff (rst)
    (run && tick && !cmd_trig && at_period) |=> (cnt == '0));  // R3
  AST_STOPPED_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!run && !cmd_trig) |=> $stable(cnt));  // R9
  AST_DIS_STOPS: assert property (@(posedge clk) disable iff (rst)
    cmd_dis |=> !run);  // R7
endmodule

// File: rtl/wg_outcell.sv
module wg_outcell
  import wg_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic ev_sw,
  input  logic ev_rc,
  input  logic ev_cmp,
  input  act_e act_sw,
  input  act_e act_rc,
  input  act_e act_cmp,
  output logic level
);
  always_ff @(posedge clk) begin
    if (rst)         level <= 1'b0;
    else if (ev_sw)  level <= apply_act(act_sw, level);
    else if (ev_rc)  level <= apply_act(act_rc, level);
    else if (ev_cmp) level <= apply_act(act_cmp, level);
  end

  AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!ev_sw && !ev_rc && !ev_cmp) |=> $stable(level));  // R4
  AST_SW_SET: assert property (@(posedge clk) disable iff (rst)
    (ev_sw && act_sw == ACT_SET) |=> level);  // R6
  AST_RC_BEATS_CMP: assert property (@(posedge clk) disable iff (rst)
    (!ev_sw && ev_rc && act_rc == ACT_CLR) |=> !level);  // R8
endmodule

// File: rtl/wave_pwm_pair.sv
module wave_pwm_pair
  import wg_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             slow_tick,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [CNT_W-1:0] cfg_wdata,
  input  logic             cmd_en,
  input  logic             cmd_dis,
  input  logic             cmd_trig,
  output logic [CNT_W-1:0] cnt_o,
  output logic             running_o,
  output logic             out_a,
  output logic             out_b
);
  localparam int NOUT = 2;

  mode_t            mode_q;
  logic [CNT_W-1:0] cmp_a_q, cmp_b_q, period_q;
  logic             tick, run, at_period, ev_rc;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= '0;
      cmp_a_q  <= '0;
      cmp_b_q  <= '0;
      period_q <= '0;
    end else if (cfg_we) begin
      case (cfg_sel)
        2'd0:    mode_q   <= mode_t'(cfg_wdata[MODE_W-1:0]);
        2'd1:    cmp_a_q  <= cfg_wdata;
        2'd2:    cmp_b_q  <= cfg_wdata;
        default: period_q <= cfg_wdata;
      endcase
    end
  end

  wg_prescale #(.NUM_DIV(4)) u_pre (
    .clk(clk), .rst(rst), .sel(mode_q.clk_sel),
    .slow_tick(slow_tick), .tick(tick)
  );

  wg_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick),
    .cmd_en(cmd_en), .cmd_dis(cmd_dis), .cmd_trig(cmd_trig),
    .period(period_q), .cnt(cnt), .run(run), .at_period(at_period)
  );

  assign ev_rc = run && tick && at_period;

  logic [CNT_W-1:0] cmp_val [NOUT];
  act_e             a_sw    [NOUT];
  act_e             a_rc    [NOUT];
  act_e             a_cmp   [NOUT];
  logic [NOUT-1:0]  cmp_hit;
  logic [NOUT-1:0]  lvl;

  assign cmp_val[0] = cmp_a_q;
  assign cmp_val[1] = cmp_b_q;
  assign a_sw[0]    = mode_q.a_sw;
  assign a_sw[1]    = mode_q.b_sw;
  assign a_rc[0]    = mode_q.a_rc;
  assign a_rc[1]    = mode_q.b_rc;
  assign a_cmp[0]   = mode_q.a_cmp;
  assign a_cmp[1]   = mode_q.b_cmp;

  for (genvar g = 0; g < NOUT; g++) begin : g_out
    assign cmp_hit[g] = run && tick && (cnt == cmp_val[g]);
    wg_outcell u_cell (
      .clk(clk), .rst(rst),
      .ev_sw(cmd_trig), .ev_rc(ev_rc), .ev_cmp(cmp_hit[g]),
      .act_sw(a_sw[g]), .act_rc(a_rc[g]), .act_cmp(a_cmp[g]),
      .level(lvl[g])
    );
  end

  assign cnt_o     = cnt;
  assign running_o = run;
  assign out_a     = lvl[0];
  assign out_b     = lvl[1];

  AST_PERIOD_LOAD: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_sel == 2'd3) |=> (period_q == $past(cfg_wdata)));  // R10
  AST_START: assert property (@(posedge clk) disable iff (rst)
    (cmd_en && !cmd_dis) |=> running_o);  // R7
endmodule

// File: tb/tb_wave_pwm_pair.sv
`timescale 1ns/1ps
module tb_wave_pwm_pair;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst, slow_tick, cfg_we, cmd_en, cmd_dis, cmd_trig;
  logic [1:0] cfg_sel;
  logic [CW-1:0] cfg_wdata, cnt_o;
  logic running_o, out_a, out_b;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wave_pwm_pair #(.CNT_W(CW)) dut (
    .clk(clk), .rst(rst), .slow_tick(slow_tick),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .cmd_en(cmd_en), .cmd_dis(cmd_dis), .cmd_trig(cmd_trig),
    .cnt_o(cnt_o), .running_o(running_o), .out_a(out_a), .out_b(out_b)
  );

  // ---------------- predictor built from the requirements ----------------
  logic [6:0]    m_div;
  logic [CW-1:0] m_cnt, m_ra, m_rb, m_rc;
  logic [14:0]   m_mode;
  logic          m_run, m_a, m_b, m_tk, m_erc, m_ea, m_eb;
  logic [CW+2:0] exp_q [$];

  function automatic logic act(logic [1:0] c, logic cur);
    case (c)
      2'b01:   return 1'b1;
      2'b10:   return 1'b0;
      2'b11:   return ~cur;
      default: return cur;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_div = '0; m_cnt = '0; m_ra = '0; m_rb = '0; m_rc = '0;
      m_mode = '0; m_run = 1'b0; m_a = 1'b0; m_b = 1'b0;
    end else begin
      case (m_mode[2:0])
        3'd0:    m_tk = m_div[0];
        3'd1:    m_tk = &m_div[2:0];
        3'd2:    m_tk = &m_div[4:0];
        3'd3:    m_tk = &m_div[6:0];
        default: m_tk = slow_tick;
      endcase
      m_erc = m_run && m_tk && (m_cnt == m_rc);
      m_ea  = m_run && m_tk && (m_cnt == m_ra);
      m_eb  = m_run && m_tk && (m_cnt == m_rb);
      if (cmd_trig)   m_a = act(m_mode[8:7], m_a);
      else if (m_erc) m_a = act(m_mode[6:5], m_a);
      else if (m_ea)  m_a = act(m_mode[4:3], m_a);
      if (cmd_trig)   m_b = act(m_mode[14:13], m_b);
      else if (m_erc) m_b = act(m_mode[12:11], m_b);
      else if (m_eb)  m_b = act(m_mode[10:9], m_b);
      if (cmd_trig)                m_cnt = '0;
      else if (m_run && m_tk)      m_cnt = (m_cnt == m_rc) ? '0 : m_cnt + 1'b1;
      if (cmd_dis)     m_run = 1'b0;
      else if (cmd_en) m_run = 1'b1;
      m_div = m_div + 1'b1;
      if (cfg_we) begin
        case (cfg_sel)
          2'd0:    m_mode = cfg_wdata[14:0];
          2'd1:    m_ra = cfg_wdata;
          2'd2:    m_rb = cfg_wdata;
          default: m_rc = cfg_wdata;
        endcase
      end
    end
    exp_q.push_back({m_cnt, m_run, m_a, m_b});
  end

  // ---------------- monitor: pops expectations at the falling edge --------
  task automatic check(bit ok, string tag, int act_v, int exp_v);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", tag, act_v, exp_v);
    end
  endtask

  always @(negedge clk) begin
    if (!done && exp_q.size() > 0) begin
      logic [CW+2:0] e;
      e = exp_q.pop_front();
      check(cnt_o == e[CW+2:3], "R3 counter", cnt_o, e[CW+2:3]);
      check(running_o == e[2], "R7 running", running_o, e[2]);
      check(out_a == e[1], "R4 out_a", out_a, e[1]);
      check(out_b == e[0], "R4 out_b", out_b, e[0]);
    end
  end

  // ---------------- driver tasks ----------------
  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] s, logic [CW-1:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic cmd(bit en, bit dis, bit trig);
    @(negedge clk); cmd_en = en; cmd_dis = dis; cmd_trig = trig;
    @(negedge clk); cmd_en = 1'b0; cmd_dis = 1'b0; cmd_trig = 1'b0;
  endtask

  function automatic logic [CW-1:0] mk(logic [2:0] sel, logic [1:0] acmp,
      logic [1:0] arc, logic [1:0] asw, logic [1:0] bcmp, logic [1:0] brc,
      logic [1:0] bsw);
    return CW'({bsw, brc, bcmp, asw, arc, acmp, sel});
  endfunction

  task automatic check_model(string tag);
    check(out_a == m_a && out_b == m_b && cnt_o == m_cnt, tag,
          {cnt_o, out_a, out_b}, {m_cnt, m_a, m_b});
  endtask

  task automatic measure_period(int expect_cycles, string tag);
    int n = 0;
    int guard = 0;
    logic prev;
    prev = out_a;
    while (!(prev == 1'b0 && out_a == 1'b1) && guard < 2000) begin
      prev = out_a; @(negedge clk); guard++;
    end
    prev = out_a;
    @(negedge clk); n = 1;
    while (!(prev == 1'b0 && out_a == 1'b1) && n < 2000) begin
      prev = out_a; @(negedge clk); n++;
    end
    check(n == expect_cycles, tag, n, expect_cycles);
  endtask

  // ---------------- main sequence ----------------
  initial begin
    rst = 1'b1; slow_tick = 1'b1; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
    cmd_en = 1'b0; cmd_dis = 1'b0; cmd_trig = 1'b0;
    cyc(4);
    check(cnt_o == 0 && !out_a && !out_b && !running_o, "R1 reset state",
          {cnt_o, out_a, out_b, running_o}, 0);
    rst = 1'b0;
    cyc(3);
    check(cnt_o == 0 && !out_a && !out_b && !running_o, "R1 after release",
          {cnt_o, out_a, out_b, running_o}, 0);

    // Edge-aligned A, toggling B, slow tick every cycle.
    wr(2'd3, 16'd9); wr(2'd1, 16'd3); wr(2'd2, 16'd6);
    wr(2'd0, mk(3'd4, 2'b10, 2'b01, 2'b01, 2'b11, 2'b00, 2'b10));
    cmd(1'b1, 1'b0, 1'b1);
    cyc(40);
    check_model("R5 period action");

    // Compare A equal to period: period action wins, A stays high.
    wr(2'd1, 16'd9);
    cmd(1'b0, 1'b0, 1'b1);
    begin
      bit all_hi = 1'b1;
      for (int i = 0; i < 25; i++) begin
        @(negedge clk);
        if (!out_a) all_hi = 1'b0;
      end
      check(all_hi, "R8 period beats compare", all_hi, 1);
    end

    // Stop: everything holds.
    cmd(1'b0, 1'b1, 1'b0);
    cyc(2);
    begin
      logic [CW-1:0] c0; logic a0, b0;
      c0 = cnt_o; a0 = out_a; b0 = out_b;
      cyc(10);
      check(cnt_o == c0 && out_a == a0 && out_b == b0, "R9 stopped hold",
            {cnt_o, out_a, out_b}, {c0, a0, b0});
    end
    // Trigger while stopped.
    cmd(1'b0, 1'b0, 1'b1);
    check(cnt_o == 0, "R6 trig zeroes counter", cnt_o, 0);
    check(out_a == 1'b1 && out_b == 1'b0, "R6 trig actions", {out_a, out_b}, 2'b10);
    check(!running_o, "R9 trig keeps stopped", running_o, 0);

    // Enable and disable together: disable wins.
    cmd(1'b1, 1'b1, 1'b0);
    check(!running_o, "R7 disable wins", running_o, 0);
    cmd(1'b1, 1'b0, 1'b0);
    check(running_o, "R7 enable starts", running_o, 1);

    // Period write while running, then restart.
    wr(2'd1, 16'd1); wr(2'd3, 16'd2);
    cmd(1'b0, 1'b0, 1'b1);
    begin
      int mx = 0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (int'(cnt_o) > mx) mx = int'(cnt_o);
      end
      check(mx == 2, "R10 new period used", mx, 2);
    end
    check_model("R10 model match");

    // Divided ticks: /8 then /2.
    wr(2'd3, 16'd3);
    wr(2'd0, mk(3'd1, 2'b10, 2'b01, 2'b01, 2'b11, 2'b00, 2'b10));
    cmd(1'b1, 1'b0, 1'b1);
    measure_period(32, "R2 divide by 8");
    wr(2'd3, 16'd4);
    wr(2'd0, mk(3'd0, 2'b10, 2'b01, 2'b01, 2'b11, 2'b00, 2'b10));
    cmd(1'b1, 1'b0, 1'b1);
    measure_period(10, "R2 divide by 2");

    // Irregular slow tick with toggle actions.
    wr(2'd0, mk(3'd5, 2'b11, 2'b11, 2'b10, 2'b01, 2'b10, 2'b01));
    wr(2'd2, 16'd2);
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      slow_tick = (i % 3 != 0);
    end
    slow_tick = 1'b1;
    cyc(2);
    check_model("R2 slow tick pattern");

    cyc(3);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule